// File: doc/BRIEF.md
# Serial Character Transmitter with Queued Idle and Break

This block sends characters on a single serial line. Each character goes out least significant bit first, framed by a low start bit and a high stop bit. A width control selects characters of 8 or 9 bits. When parity is switched on, the top bit of the character slot carries a parity bit that the hardware generates. That bit takes the place of the character's top data bit; no extra bit is added. Each bit lasts a number of clock cycles set by a divider input.

A one-entry holding register sits in front of the shifter. Two flags report on it. A data-empty flag shows that the holding register can take a new character. A completion flag shows that nothing at all is left to send. An interrupt request combines these flags with their enables. Clearing the enable and setting it again while a frame is on the line queues one idle character, which is a full character time of high line with no start bit. A rising edge on the break request queues a break character, which is a full character time of low line. An ownership output stays high while the enable is set or while anything already committed to the line is still draining. The surrounding logic can give the pin back to general-purpose use once it falls.

Top module: `sertx_core`

## Requirements
- R1: After reset, txd is 1, tdre is 1 and tc is 1. With tx_en at 0, pin_own is 0. With both interrupt enables at 0, irq is 0.
- R2: A data frame has a start bit of 0, then N character bits least significant first, then a stop bit of 1. N is 9 when nine_bit is 1 and 8 when it is 0. Each bit lasts baud_div clock cycles, and a baud_div of 0 acts as 1. Frames start in the clock cycle after a load. Two frames in a row are separated by one clock cycle of high line.
- R3: With par_en at 1, the top character bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is replaced by generated parity. The number of ones in the character including that bit is even when par_odd is 0 and odd when par_odd is 1.
- R4: An accepted write (wr_valid at 1 while tdre is 1) clears tdre. tdre sets again when the held character moves into the shifter. A write while tdre is 0 is ignored and its character is never sent.
- R5: tc is 1 exactly when the shifter is idle, the holding register is empty, and no idle or break character is queued.
- R6: irq is 1 when tdre_ie and tdre are both 1, or when tc_ie and tc are both 1. Otherwise irq is 0.
- R7: A rising edge of tx_en while a frame is on the line queues one idle character. The idle character is N+2 bit times of high line. It is sent after the current frame and ahead of any held data.
- R8: A rising edge of brk_req while tx_en is 1 queues one break character of N+2 bit times of low line. A break takes priority over a queued idle and over held data. A break request while tx_en is 0 is ignored.
- R9: While tx_en is 0, a held character is not started. After tx_en clears, pin_own stays 1 until the frame in progress and any queued idle or break have finished, and then it goes to 0. Whenever pin_own is 0, txd is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Clock cycles per bit (0 acts as 1) |
| tx_en | input | 1 | Transmitter enable; a rise during a frame queues idle |
| par_en | input | 1 | Replace the top character bit with parity |
| par_odd | input | 1 | 0 selects even parity, 1 selects odd |
| nine_bit | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| brk_req | input | 1 | A rising edge queues a break character |
| tdre_ie | input | 1 | Interrupt enable for tdre |
| tc_ie | input | 1 | Interrupt enable for tc |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | All transmission finished |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial line |
| pin_own | output | 1 | The transmitter owns the line |

## Verification
Some relations hold on every cycle, and the checker tests them there. Completion implies an empty holding register. The interrupt follows its enabled flags. The line is high whenever ownership is released, and ownership is held whenever the enable is set. The empty flag falls only after a write. Whether the bits come out in the right order and at the right length, whether parity and the idle and break characters are correct, and how queued work is ordered against held data can only be shown by the bench. Its reference model replays the scenarios, such as toggling the enable in mid-frame, raising break with data pending, and disabling with a full holding register, and compares the line and flags on every clock.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
   // what the shifter is given when it takes a new frame
   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_DATA = 2'd1,
      LD_IDLE = 2'd2,
      LD_BRK  = 2'd3
   } ld_kind_e;
endpackage

// File: rtl/sertx_arb.sv
`timescale 1ns/1ps
// holding register, idle/break queue and load priority
module sertx_arb
   import sertx_pkg::*;
#(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              brk_req,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              shift_busy,
   output ld_kind_e          ld_kind,
   output logic [DATA_W-1:0] hold_q,
   output logic              hold_full,
   output logic              q_idle,
   output logic              q_brk
);
   logic en_q, brk_q;
   logic en_rise, brk_rise;

   assign en_rise  = tx_en & ~en_q;
   assign brk_rise = brk_req & ~brk_q & tx_en;

   // break before idle before data; queued work drains even while disabled
   always_comb begin
      ld_kind = LD_NONE;
      if (!shift_busy) begin
         if (q_brk)                  ld_kind = LD_BRK;
         else if (q_idle)            ld_kind = LD_IDLE;
         else if (hold_full && tx_en) ld_kind = LD_DATA;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         brk_q     <= 1'b0;
         q_brk     <= 1'b0;
         q_idle    <= 1'b0;
         hold_full <= 1'b0;
         hold_q    <= '0;
      end else begin
         en_q  <= tx_en;
         brk_q <= brk_req;
         if (ld_kind == LD_BRK)  q_brk  <= 1'b0;
         if (brk_rise)           q_brk  <= 1'b1;
         if (ld_kind == LD_IDLE) q_idle <= 1'b0;
         if (en_rise && shift_busy) q_idle <= 1'b1;
         if (ld_kind == LD_DATA) begin
            hold_full <= 1'b0;
         end else if (wr_valid && !hold_full) begin
            hold_full <= 1'b1;
            hold_q    <= wr_data;
         end
      end
   end
endmodule

// File: rtl/sertx_frame.sv
`timescale 1ns/1ps
// builds the frame vector (bit 0 goes out first) and its length
module sertx_frame
   import sertx_pkg::*;
#(
   parameter int DATA_W     = 9,
   parameter bit HAS_PARITY = 1'b1,
   localparam int FRM_W     = DATA_W + 2,
   localparam int LEN_W     = $clog2(FRM_W + 1)
) (
   input  ld_kind_e          ld_kind,
   input  logic [DATA_W-1:0] hold_q,
   input  logic              nine_bit,
   input  logic              par_en,
   input  logic              par_odd,
   output logic [FRM_W-1:0]  frm,
   output logic [LEN_W-1:0]  frm_len
);
   logic par_on;
   logic wide_par, narrow_par;
   logic [DATA_W-1:0] chr;

   generate
      if (HAS_PARITY) begin : g_par
         assign par_on = par_en;
      end else begin : g_nopar
         assign par_on = 1'b0;
      end
   endgenerate

   assign wide_par   = (^hold_q[DATA_W-2:0]) ^ par_odd;
   assign narrow_par = (^hold_q[DATA_W-3:0]) ^ par_odd;

   always_comb begin
      chr = hold_q;
      if (par_on) begin
         if (nine_bit) chr[DATA_W-1] = wide_par;
         else          chr[DATA_W-2] = narrow_par;
      end
      case (ld_kind)
         LD_IDLE: frm = '1;
         LD_BRK:  frm = '0;
         default: frm = nine_bit ? {1'b1, chr, 1'b0}
                                 : {2'b11, chr[DATA_W-2:0], 1'b0};
      endcase
      frm_len = nine_bit ? LEN_W'(FRM_W) : LEN_W'(FRM_W - 1);
   end
endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
// shift register with its own bit-time counter
module sertx_shift #(
   parameter int FRM_W = 11,
   parameter int DIV_W = 16,
   localparam int LEN_W = $clog2(FRM_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [FRM_W-1:0] frm,
   input  logic [LEN_W-1:0] frm_len,
   input  logic [DIV_W-1:0] baud_div,
   output logic             busy,
   output logic             bit_out
);
   logic [FRM_W-1:0] shreg;
   logic [LEN_W-1:0] left;
   logic [DIV_W-1:0] cyc;
   logic [DIV_W-1:0] div_last;

   assign div_last = (baud_div == '0) ? '0 : baud_div - DIV_W'(1);
   assign bit_out  = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         cyc   <= '0;
      end else if (load) begin
         busy  <= 1'b1;
         shreg <= frm;
         left  <= frm_len - LEN_W'(1);
         cyc   <= '0;
      end else if (busy) begin
         if (cyc == div_last) begin
            cyc <= '0;
            if (left == '0) begin
               busy <= 1'b0;
            end else begin
               shreg <= {1'b1, shreg[FRM_W-1:1]};
               left  <= left - LEN_W'(1);
            end
         end else begin
            cyc <= cyc + DIV_W'(1);
         end
      end
   end
endmodule

// File: rtl/sertx_core.sv
`timescale 1ns/1ps
module sertx_core
   import sertx_pkg::*;
#(
   parameter int DATA_W     = 9,
   parameter int DIV_W      = 16,
   parameter bit HAS_PARITY = 1'b1,
   localparam int FRM_W     = DATA_W + 2,
   localparam int LEN_W     = $clog2(FRM_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              tx_en,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              nine_bit,
   input  logic              brk_req,
   input  logic              tdre_ie,
   input  logic              tc_ie,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tdre,
   output logic              tc,
   output logic              irq,
   output logic              txd,
   output logic              pin_own
);
   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("sertx_core: DATA_W must be at least 3");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sertx_core: DIV_W must be at least 1");
      end
   endgenerate

   ld_kind_e          ld_kind;
   logic [DATA_W-1:0] hold_q;
   logic              hold_full, q_idle, q_brk, busy;
   logic [FRM_W-1:0]  frm;
   logic [LEN_W-1:0]  frm_len;

   sertx_arb #(.DATA_W(DATA_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
      .wr_valid(wr_valid), .wr_data(wr_data), .shift_busy(busy),
      .ld_kind(ld_kind), .hold_q(hold_q), .hold_full(hold_full),
      .q_idle(q_idle), .q_brk(q_brk)
   );

   sertx_frame #(.DATA_W(DATA_W), .HAS_PARITY(HAS_PARITY)) u_frame (
      .ld_kind(ld_kind), .hold_q(hold_q), .nine_bit(nine_bit),
      .par_en(par_en), .par_odd(par_odd), .frm(frm), .frm_len(frm_len)
   );

   sertx_shift #(.FRM_W(FRM_W), .DIV_W(DIV_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(ld_kind != LD_NONE), .frm(frm),
      .frm_len(frm_len), .baud_div(baud_div), .busy(busy), .bit_out(txd)
   );

   assign tdre    = ~hold_full;
   assign tc      = ~busy & ~hold_full & ~q_idle & ~q_brk;
   assign irq     = (tdre_ie & tdre) | (tc_ie & tc);
   assign pin_own = tx_en | busy | q_idle | q_brk;
endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_valid,
   input logic tdre,
   input logic tc,
   input logic tdre_ie,
   input logic tc_ie,
   input logic irq,
   input logic txd,
   input logic pin_own
);
   assert_tc_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> tdre);
   assert_load_not_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> !tc);
   assert_irq_tc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_ie && tc) |-> irq);
   assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tdre_ie && !tc_ie) |-> !irq);
   assert_tdre_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tdre) |-> $past(wr_valid));
   assert_released_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_own |-> txd);
   assert_owned_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> pin_own);
endmodule

bind sertx_core sertx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_valid(wr_valid),
   .tdre(tdre), .tc(tc), .tdre_ie(tdre_ie), .tc_ie(tc_ie),
   .irq(irq), .txd(txd), .pin_own(pin_own)
);

// File: tb/sertx_core_tb.sv
`timescale 1ns/1ps
module sertx_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div = 16'd3;
   logic        en = 1'b0, par = 1'b0, odd = 1'b0, nine = 1'b0, brk = 1'b0;
   logic        tie = 1'b0, tcie = 1'b0, wr = 1'b0;
   logic [8:0]  wdata = '0;
   logic        tdre, tc, irq, txd, pin_own;

   int checks = 0, fails = 0, cycles = 0;
   string phase = "R1";
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   sertx_core u_dut (
      .clk(clk), .rst_n(rst_n), .baud_div(div), .tx_en(en), .par_en(par),
      .par_odd(odd), .nine_bit(nine), .brk_req(brk), .tdre_ie(tie),
      .tc_ie(tcie), .wr_valid(wr), .wr_data(wdata), .tdre(tdre), .tc(tc),
      .irq(irq), .txd(txd), .pin_own(pin_own)
   );

   // behavioural reference: a queue of line bits plus flags
   bit         mq[$];
   int         m_cyc = 0;
   bit         m_busy = 0, m_hold = 0, m_qi = 0, m_qb = 0, m_enq = 0, m_brkq = 0;
   logic [8:0] m_data = '0;

   function automatic bit m_tc();
      return !m_busy && !m_hold && !m_qi && !m_qb;
   endfunction

   always @(posedge clk) begin
      bit o_busy, o_hold, o_qi, o_qb;
      int dv, n, ones;
      if (!rst_n) begin
         mq.delete(); m_cyc = 0; m_busy = 0; m_hold = 0; m_qi = 0; m_qb = 0;
         m_enq = 0; m_brkq = 0;
      end else begin
         o_busy = m_busy; o_hold = m_hold; o_qi = m_qi; o_qb = m_qb;
         dv = (div == 0) ? 1 : int'(div);
         n  = nine ? 9 : 8;
         if (o_busy) begin
            if (m_cyc == dv - 1) begin
               m_cyc = 0;
               void'(mq.pop_front());
               if (mq.size() == 0) m_busy = 0;
            end else m_cyc++;
         end else if (o_qb) begin
            m_qb = 0; m_busy = 1; m_cyc = 0;
            for (int i = 0; i < n + 2; i++) mq.push_back(1'b0);
         end else if (o_qi) begin
            m_qi = 0; m_busy = 1; m_cyc = 0;
            for (int i = 0; i < n + 2; i++) mq.push_back(1'b1);
         end else if (o_hold && en) begin
            m_hold = 0; m_busy = 1; m_cyc = 0;
            ones = 0;
            for (int i = 0; i < n - 1; i++) ones += m_data[i];
            mq.push_back(1'b0);
            for (int i = 0; i < n; i++) begin
               if (par && i == n - 1) mq.push_back(odd ? ((ones % 2) == 0) : ((ones % 2) == 1));
               else mq.push_back(m_data[i]);
            end
            mq.push_back(1'b1);
         end
         if (brk && !m_brkq && en) m_qb = 1;
         if (en && !m_enq && o_busy) m_qi = 1;
         if (wr && !o_hold) begin m_hold = 1; m_data = wdata; end
         m_enq = en; m_brkq = brk;
      end
   end

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s [%s] %s: got %b expected %b at cycle %0d", req, phase, what, got, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk(txd, m_busy ? mq[0] : 1'b1, "R2", "txd");
         chk(tdre, !m_hold, "R4", "tdre");
         chk(tc, m_tc(), "R5", "tc");
         chk(irq, (tie && !m_hold) || (tcie && m_tc()), "R6", "irq");
         chk(pin_own, en || m_busy || m_qi || m_qb, "R9", "pin_own");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic step(input int k);
      repeat (k) @(posedge clk);
      #1;
   endtask

   task automatic put(input logic [8:0] d);
      wr = 1'b1; wdata = d;
      step(1);
      wr = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 5000 && !m_tc(); i++) step(1);
      step(2);
   endtask

   initial begin
      step(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd, 1'b1, "R1", "txd after reset");
      chk(tdre, 1'b1, "R1", "tdre after reset");
      chk(tc, 1'b1, "R1", "tc after reset");
      chk(pin_own, 1'b0, "R1", "pin_own after reset");
      chk(irq, 1'b0, "R1", "irq after reset");
      step(1);
      cmp_on = 1'b1;
      en = 1'b1;
      step(1);

      phase = "R2 8-bit";
      put(9'h0A5); drain();
      phase = "R4 write while full";
      div = 16'd1;
      put(9'h03C); put(9'h081); drain();
      put(9'h0C3); step(2); put(9'h018); drain();
      phase = "R2 div zero nine-bit";
      div = 16'd0; nine = 1'b1;
      put(9'h1B2); drain();

      phase = "R3 parity";
      div = 16'd2; nine = 1'b0; par = 1'b1; odd = 1'b0;
      put(9'h007); drain();
      odd = 1'b1; put(9'h007); drain();
      put(9'h0FF); drain();
      nine = 1'b1; odd = 1'b0; put(9'h0F3); drain();
      odd = 1'b1; put(9'h0F3); drain();
      par = 1'b0; put(9'h155); drain();

      phase = "R7 queued idle";
      nine = 1'b0;
      put(9'h055); step(3); put(9'h066);
      en = 1'b0; step(1); en = 1'b1; step(1);
      drain();

      phase = "R8 break priority";
      put(9'h011); step(2); put(9'h022);
      en = 1'b0; step(1); en = 1'b1;
      brk = 1'b1; step(1); brk = 1'b0;
      drain();

      phase = "R9 disable drains";
      put(9'h033); step(2); put(9'h044);
      en = 1'b0; step(1);
      brk = 1'b1; step(1); brk = 1'b0;
      step(60);
      en = 1'b1; drain();
      en = 1'b0; step(1); en = 1'b1;
      brk = 1'b1; step(1); brk = 1'b0; step(1); en = 1'b0;
      step(40); en = 1'b1; step(2);

      phase = "R6 interrupts";
      tie = 1'b1; step(2); put(9'h0AA); step(5);
      tie = 1'b0; tcie = 1'b1; drain();
      tie = 1'b1; put(9'h05A); drain();
      tie = 1'b0; tcie = 1'b0; step(3);

      cmp_on = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule